// File: doc/BRIEF.md
# Burst-of-Two Separate-IO SRAM Pipeline

This block is a synthesizable model of a memory with a write data port and a read data port that share one address per clock. Every cycle it looks at two active-low strobes, one for reading and one for writing, and treats the cycle as idle, store-only, fetch-only or fetch-and-store. A store takes a two-beat word at the sampled address. The beats that would arrive on the two halves of the clock are presented here as two parallel inputs. A fetch returns the two-beat word at that address three cycles later. A beat-select input chooses which half of the returned word is on the output bus.

On a cycle that returns no fetched data, the output bus goes to an idle state. With termination mode on, the bus is driven to zero. With termination mode off, the output enable is low. The termination choice is taken in the command cycle and carried down the read pipeline with the command. Storage is a register array with a configurable number of entries and a configurable beat width. Reset clears the pipeline and leaves the array contents alone.

Top module: `b2_sram_pipe`

## Requirements
- R1: With `wr_n_i` low at a rising edge, `wdata0_i` and `wdata1_i` are stored as beat 0 and beat 1 of the entry at `addr_i`, and a later fetch of that address returns them.
- R2: With `rd_n_i` low at rising edge k, the output holds the fetched word after edge k+2 until edge k+3, with `rdata_oe_o` high. `beat_sel_i` = 0 selects beat 0 and `beat_sel_i` = 1 selects beat 1.
- R3: When both strobes are low, the fetch and the store use the same address, and the fetch returns the contents from before that cycle's store.
- R4: An idle or store-only command with `term_en_i` = 1 gives `rdata_oe_o` = 1 and `rdata_o` = 0 for both beats in the output cycle three cycles later.
- R5: An idle or store-only command with `term_en_i` = 0 gives `rdata_oe_o` = 0 in the output cycle. `rdata_o` is 0 whenever `rdata_oe_o` is 0.
- R6: Fetches on consecutive cycles give consecutive output cycles with `rdata_oe_o` held high and no gap between them.
- R7: An idle command (both strobes high) changes no stored entry, whatever `addr_i` and the write data inputs carry.
- R8: While reset is asserted, and for the first three output cycles after it is released, `rdata_oe_o` = 0 and `rdata_o` = 0. Reset does not alter the stored entries.
- R9: The idle-state choice follows `term_en_i` as sampled with the command, not its value in the output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_n_i | input | 1 | Fetch strobe, active low |
| wr_n_i | input | 1 | Store strobe, active low |
| addr_i | input | AW | Shared address, ignored on idle cycles |
| wdata0_i | input | DW | Store beat 0 (first half) |
| wdata1_i | input | DW | Store beat 1 (second half) |
| term_en_i | input | 1 | Termination mode, sampled with the command |
| beat_sel_i | input | 1 | Output beat select: 0 = beat 0, 1 = beat 1 |
| rdata_o | output | DW | Fetched beat or idle value |
| rdata_oe_o | output | 1 | Output enable for the fetch bus |

## Verification
Directed sequences come first. The bench fills every entry and reads them back on consecutive cycles, which separates a continuous output from one with gaps. It then issues fetch-and-store to one address and a plain fetch afterwards, which separates read-before-write from write-through. Idle cycles are issued with stray addresses and data and their idle state is checked under both termination modes. `term_en_i` is flipped between the command cycle and the output cycle, which shows whether the mode is carried with the command. A reset while fetches are in flight shows that the pipeline is cleared and the array is kept. A long random mix of all four commands over random addresses and data finishes the run, checked against a bench model of the array and pipeline on both beats every cycle.

// File: rtl/b2_sram_pkg.sv
`timescale 1ns/1ps
package b2_sram_pkg;
  localparam int BEATS = 2;

  // encoding is {rd_n, wr_n}
  typedef enum logic [1:0] {
    CMD_RW  = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_NOP = 2'b11
  } cmd_e;

  function automatic cmd_e decode_cmd(logic rd_n, logic wr_n);
    return cmd_e'({rd_n, wr_n});
  endfunction
endpackage

// File: rtl/b2_cmd_decode.sv
`timescale 1ns/1ps
module b2_cmd_decode
  import b2_sram_pkg::*;
(
  input  logic rd_n_i,
  input  logic wr_n_i,
  output logic rd_en_o,
  output logic wr_en_o
);
  cmd_e cmd;

  always_comb begin
    cmd = decode_cmd(rd_n_i, wr_n_i);
    rd_en_o = 1'b0;
    wr_en_o = 1'b0;
    unique case (cmd)
      CMD_RW:  begin rd_en_o = 1'b1; wr_en_o = 1'b1; end
      CMD_RD:  rd_en_o = 1'b1;
      CMD_WR:  wr_en_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/b2_store.sv
`timescale 1ns/1ps
module b2_store
  import b2_sram_pkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [BEATS-1:0][DW-1:0]  wbeats_i,
  output logic [BEATS-1:0][DW-1:0]  rbeats_o
);
  logic [BEATS-1:0][DW-1:0] rows [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [BEATS-1:0][DW-1:0] row_q;
    logic                     hit;
    assign hit = wr_en_i && (addr_i == AW'(r));
    always_ff @(posedge clk_i) begin
      if (hit) row_q <= wbeats_i;
    end
    assign rows[r] = row_q;
  end

  // combinational read: the caller registers it at the edge that also writes
  assign rbeats_o = rows[addr_i];
endmodule

// File: rtl/b2_rd_pipe.sv
`timescale 1ns/1ps
module b2_rd_pipe
  import b2_sram_pkg::*;
#(
  parameter int DW     = 18,
  parameter int RD_LAT = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_vld_i,
  input  logic                      push_term_i,
  input  logic [BEATS-1:0][DW-1:0]  push_beats_i,
  output logic                      out_vld_o,
  output logic                      out_term_o,
  output logic [BEATS-1:0][DW-1:0]  out_beats_o
);
  logic [RD_LAT-1:0]        vld_q;
  logic [RD_LAT-1:0]        term_q;
  logic [BEATS-1:0][DW-1:0] beats_q [RD_LAT];

  for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
    logic                     vld_d;
    logic                     term_d;
    logic [BEATS-1:0][DW-1:0] beats_d;

    if (s == 0) begin : g_head
      assign vld_d   = push_vld_i;
      assign term_d  = push_term_i;
      assign beats_d = push_beats_i;
    end else begin : g_body
      assign vld_d   = vld_q[s-1];
      assign term_d  = term_q[s-1];
      assign beats_d = beats_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s]  <= 1'b0;
        term_q[s] <= 1'b0;
      end else begin
        vld_q[s]  <= vld_d;
        term_q[s] <= term_d;
      end
    end

    // data lanes need no reset; the valid bit masks them
    always_ff @(posedge clk_i) begin
      if (vld_d) beats_q[s] <= beats_d;
    end
  end

  assign out_vld_o   = vld_q[RD_LAT-1];
  assign out_term_o  = term_q[RD_LAT-1];
  assign out_beats_o = beats_q[RD_LAT-1];
endmodule

// File: rtl/b2_q_drive.sv
`timescale 1ns/1ps
module b2_q_drive
  import b2_sram_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic                      vld_i,
  input  logic                      term_i,
  input  logic [BEATS-1:0][DW-1:0]  beats_i,
  input  logic                      beat_sel_i,
  output logic [DW-1:0]             q_o,
  output logic                      oe_o
);
  always_comb begin
    if (vld_i) begin
      q_o  = beats_i[beat_sel_i];
      oe_o = 1'b1;
    end else begin
      q_o  = '0;
      oe_o = term_i;   // terminated idle drives low, else float
    end
  end
endmodule

// File: rtl/b2_sram_pipe.sv
`timescale 1ns/1ps
module b2_sram_pipe
  import b2_sram_pkg::*;
#(
  parameter int DW     = 18,
  parameter int DEPTH  = 16,
  parameter int RD_LAT = 3,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata0_i,
  input  logic [DW-1:0] wdata1_i,
  input  logic          term_en_i,
  input  logic          beat_sel_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_oe_o
);
  logic                     rd_en, wr_en;
  logic [BEATS-1:0][DW-1:0] wbeats, rbeats;
  logic                     tail_vld, tail_term;
  logic [BEATS-1:0][DW-1:0] tail_beats;

  assign wbeats = {wdata1_i, wdata0_i};

  b2_cmd_decode u_dec (
    .rd_n_i  (rd_n_i),
    .wr_n_i  (wr_n_i),
    .rd_en_o (rd_en),
    .wr_en_o (wr_en)
  );

  b2_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en),
    .addr_i   (addr_i),
    .wbeats_i (wbeats),
    .rbeats_o (rbeats)
  );

  b2_rd_pipe #(.DW(DW), .RD_LAT(RD_LAT)) u_pipe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_vld_i   (rd_en),
    .push_term_i  (term_en_i),
    .push_beats_i (rbeats),
    .out_vld_o    (tail_vld),
    .out_term_o   (tail_term),
    .out_beats_o  (tail_beats)
  );

  b2_q_drive #(.DW(DW)) u_drv (
    .vld_i      (tail_vld),
    .term_i     (tail_term),
    .beats_i    (tail_beats),
    .beat_sel_i (beat_sel_i),
    .q_o        (rdata_o),
    .oe_o       (rdata_oe_o)
  );
endmodule

// File: rtl/b2_sram_pipe_chk.sv
`timescale 1ns/1ps
module b2_sram_pipe_chk #(
  parameter int DW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_n_i,
  input logic          term_en_i,
  input logic [DW-1:0] rdata_o,
  input logic          rdata_oe_o
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd3) |-> (!rdata_oe_o && rdata_o == '0));

  assert_read_drives_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && !$past(rd_n_i, 3)) |-> rdata_oe_o);

  assert_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && $past(rd_n_i, 3) && $past(term_en_i, 3))
      |-> (rdata_oe_o && rdata_o == '0));

  assert_idle_float_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && $past(rd_n_i, 3) && !$past(term_en_i, 3))
      |-> !rdata_oe_o);

  assert_float_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> (rdata_o == '0));
endmodule

bind b2_sram_pipe b2_sram_pipe_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_n_i     (rd_n_i),
  .term_en_i  (term_en_i),
  .rdata_o    (rdata_o),
  .rdata_oe_o (rdata_oe_o)
);

// File: tb/b2_sram_pipe_bench.sv
`timescale 1ns/1ps
module b2_sram_pipe_bench;
  localparam int DW = 18, DEPTH = 16, AW = 4, LAT = 3;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          rd_n = 1'b1, wr_n = 1'b1, term_en = 1'b0, beat_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd0 = '0, wd1 = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  always #2 clk = ~clk;

  b2_sram_pipe #(.DW(DW), .DEPTH(DEPTH), .RD_LAT(LAT)) u_b2_sram_pipe (
    .clk_i(clk), .rst_ni(rst_ni), .rd_n_i(rd_n), .wr_n_i(wr_n), .addr_i(addr),
    .wdata0_i(wd0), .wdata1_i(wd1), .term_en_i(term_en), .beat_sel_i(beat_sel),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  // bench model
  logic [DW-1:0] m0 [DEPTH], m1 [DEPTH];
  bit            p_vld [LAT], p_term [LAT];
  logic [DW-1:0] p_b0 [LAT], p_b1 [LAT];
  string         p_tag [LAT];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  function automatic logic exp_oe(bit v, bit t);
    return v | t;
  endfunction

  function automatic logic [DW-1:0] exp_q(bit v, logic [DW-1:0] b);
    return v ? b : '0;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] aq, logic [DW-1:0] eq, logic aoe, logic eoe);
    n_vec++;
    if (aq !== eq || aoe !== eoe) begin
      n_bad++;
      $display("FAIL %s: q=%h oe=%b expected q=%h oe=%b", tag, aq, aoe, eq, eoe);
    end
  endtask

  task automatic clear_pipe(string tag);
    for (int s = 0; s < LAT; s++) begin
      p_vld[s] = 0; p_term[s] = 0; p_b0[s] = '0; p_b1[s] = '0; p_tag[s] = tag;
    end
  endtask

  task automatic cyc(bit rn, bit wn, logic [AW-1:0] a, logic [DW-1:0] d0,
                     logic [DW-1:0] d1, bit te, string tag);
    @(negedge clk);
    beat_sel = 1'b0; #0.5;
    chk(p_tag[LAT-1], rdata, exp_q(p_vld[LAT-1], p_b0[LAT-1]), rdata_oe,
        exp_oe(p_vld[LAT-1], p_term[LAT-1]));
    beat_sel = 1'b1; #0.5;
    chk(p_tag[LAT-1], rdata, exp_q(p_vld[LAT-1], p_b1[LAT-1]), rdata_oe,
        exp_oe(p_vld[LAT-1], p_term[LAT-1]));
    beat_sel = 1'b0;
    rd_n = rn; wr_n = wn; addr = a; wd0 = d0; wd1 = d1; term_en = te;
    for (int s = LAT-1; s > 0; s--) begin
      p_vld[s] = p_vld[s-1]; p_term[s] = p_term[s-1];
      p_b0[s] = p_b0[s-1]; p_b1[s] = p_b1[s-1]; p_tag[s] = p_tag[s-1];
    end
    p_vld[0] = !rn; p_term[0] = te; p_tag[0] = tag;
    p_b0[0] = m0[a]; p_b1[0] = m1[a];   // read sees contents before this store
    if (!wn) begin m0[a] = d0; m1[a] = d1; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; term_en = 1'b0;
    rst_ni = 1'b0; #0.5;
    chk("R8", rdata, '0, rdata_oe, 1'b0);
    rst_ni = 1'b1;
    clear_pipe("R8");
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got no end expected end");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] r0, r1;
    void'($urandom(32'h1b2c3d));
    clear_pipe("R8");
    repeat (2) @(negedge clk);
    do_reset();
    // R8: first output cycles after reset stay idle
    for (int i = 0; i < 3; i++) cyc(1, 1, '0, '0, '0, 0, "R8");

    // R1/R4: fill with store-only, terminated idle
    for (int a = 0; a < DEPTH; a++)
      cyc(1, 0, AW'(a), DW'($urandom), DW'($urandom), 1, "R4");
    // R6/R1: back-to-back fetches of every entry
    for (int a = 0; a < DEPTH; a++) cyc(0, 1, AW'(a), '0, '0, 0, "R6");

    // R3: fetch-and-store returns old contents, then new
    cyc(0, 0, 4'd5, 18'h2aaaa, 18'h15555, 0, "R3");
    cyc(0, 0, 4'd5, 18'h00f0f, 18'h3f0f0, 1, "R3");
    cyc(0, 1, 4'd5, '0, '0, 0, "R1");

    // R7/R5: idle with stray address and data, floating idle
    for (int i = 0; i < 8; i++)
      cyc(1, 1, AW'($urandom), DW'($urandom), DW'($urandom), 0, "R5");
    for (int a = 0; a < DEPTH; a++) cyc(0, 1, AW'(a), '0, '0, 1, "R7");

    // R9: mode flips after the command cycle
    cyc(1, 1, '0, '0, '0, 1, "R9");
    cyc(1, 1, '0, '0, '0, 0, "R9");
    cyc(1, 0, 4'd3, 18'h12345, 18'h0abcd, 1, "R9");
    cyc(1, 1, '0, '0, '0, 0, "R5");
    cyc(1, 1, '0, '0, '0, 1, "R4");

    // R8: reset with fetches in flight, array kept
    cyc(0, 1, 4'd3, '0, '0, 0, "R8");
    cyc(0, 1, 4'd7, '0, '0, 0, "R8");
    r0 = m0[3]; r1 = m1[3];
    do_reset();
    for (int i = 0; i < 3; i++) cyc(1, 1, '0, '0, '0, 0, "R8");
    cyc(0, 1, 4'd3, '0, '0, 0, "R8");
    if (r0 !== m0[3] || r1 !== m1[3]) begin
      n_bad++;
      $display("FAIL R8: model changed %h %h expected %h %h", m0[3], m1[3], r0, r1);
    end

    // R2: random mix of all commands
    for (int i = 0; i < 3000; i++)
      cyc($urandom % 3 == 0, $urandom % 2 == 0, AW'($urandom),
          DW'($urandom), DW'($urandom), 1'($urandom), "R2");
    for (int i = 0; i < LAT; i++) cyc(1, 1, '0, '0, '0, 0, "R5");
    finish_run();
  end
endmodule